// File: doc/BRIEF.md
# Rank-Ordered Issue Picker

This block sits beside an instruction queue and chooses at most one entry to send to execution each cycle. Every queue slot presents four things: a ready bit, an 8-bit program-order tag, a 4-bit count of known consumers of its result, and a busy bit. The busy bit is set when the execution resource that the slot needs is already taken.

The picker gives each slot a signed score. The score is the order tag minus the consumer count. An entry whose result feeds many later instructions can therefore move ahead of older entries. The lowest score wins. A tie in score goes to the older tag, and a tie in both goes to the lowest slot index.

The choice is made by a combinational reduction tree across all slots. It is registered on the clock edge as a one-hot grant vector, a binary slot index and a found flag. Storage of the entries, wakeup and resource bookkeeping belong to the blocks around it.

Top module: `rank_issue_picker`

## Requirements
- R1: The score of slot i is the signed 9-bit value tag_i − users_i. It goes negative when the consumer count exceeds the tag, and the bits of slot i sit at `seq_i[8*i +: 8]` and `users_i[4*i +: 4]`.
- R2: Among eligible slots, the one with the numerically lowest score is picked.
- R3: When eligible slots share the lowest score, the one with the smaller order tag is picked.
- R4: When score and tag are both equal, the lowest slot index is picked.
- R5: A slot whose `busy_i` bit is 1 is never picked, even if it would otherwise win.
- R6: A slot whose `ready_i` bit is 0 is never picked, whatever its tag and count.
- R7: When no slot is eligible (eligible means ready=1 and busy=0), `found_o` is 0, `grant_o` is all zeros and `sel_idx_o` is 0.
- R8: Outputs are registered. The pick made from the inputs present before a rising clock edge appears on the outputs right after that edge, and it is held until the next edge.
- R9: When `found_o` is 1, `grant_o` has exactly one bit set, at position `sel_idx_o`.
- R10: While `rst_n` is low, `found_o`, `grant_o` and `sel_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | 16 | Per-slot ready bit |
| busy_i | input | 16 | Per-slot resource-busy bit |
| seq_i | input | 128 | Per-slot 8-bit program-order tag, packed |
| users_i | input | 64 | Per-slot 4-bit consumer count, packed |
| grant_o | output | 16 | Registered one-hot grant |
| sel_idx_o | output | 4 | Registered index of the granted slot |
| found_o | output | 1 | Registered flag, 1 when a slot was granted |

## Verification
The ordering checks compare tags as plain unsigned numbers. They therefore assume that the live tags never wrap inside the window of outstanding entries. The stimulus keeps every tag within a span of at most 100 values, starting from a base below 128, so that assumption always holds. Busy and ready bits are treated as arbitrary per cycle, so random patterns drive them freely. Directed cases build each tie and each negative score on purpose.

// File: rtl/picker_pkg.sv
package picker_pkg;

  localparam int SEQ_W       = 8;
  localparam int USE_W       = 4;
  localparam int RANK_W      = SEQ_W + 1;
  localparam int MAX_ENTRIES = 16;
  localparam int IDX_W       = $clog2(MAX_ENTRIES);

  typedef struct packed {
    logic                     vld;
    logic signed [RANK_W-1:0] rank;
    logic [SEQ_W-1:0]         seq;
    logic [IDX_W-1:0]         idx;
  } cand_t;

  // 1 when candidate a (lower index side) should be kept over b
  function automatic logic cand_beats(input cand_t a, input cand_t b);
    logic keep_a;
    if (!b.vld) begin
      keep_a = 1'b1;
    end else if (!a.vld) begin
      keep_a = 1'b0;
    end else if (a.rank != b.rank) begin
      keep_a = (a.rank < b.rank);
    end else if (a.seq != b.seq) begin
      keep_a = (a.seq < b.seq);
    end else begin
      keep_a = 1'b1;
    end
    return keep_a;
  endfunction

endpackage

// File: rtl/picker_rank_leaf.sv
module picker_rank_leaf
  import picker_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic             ready_i,
  input  logic             busy_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [USE_W-1:0] users_i,
  output cand_t            cand_o
);

  localparam int PAD_W = RANK_W - USE_W;

  logic signed [RANK_W-1:0] seq_ext;
  logic signed [RANK_W-1:0] use_ext;

  always_comb begin
    seq_ext     = $signed({1'b0, seq_i});
    use_ext     = $signed({{PAD_W{1'b0}}, users_i});
    cand_o.vld  = ready_i & ~busy_i;
    cand_o.rank = seq_ext - use_ext;
    cand_o.seq  = seq_i;
    cand_o.idx  = IDX_W'(SLOT);
  end

endmodule

// File: rtl/picker_merge_node.sv
module picker_merge_node
  import picker_pkg::*;
(
  input  cand_t lo_i,
  input  cand_t hi_i,
  output cand_t win_o
);

  logic take_lo;

  always_comb begin
    take_lo = cand_beats(lo_i, hi_i);
    win_o   = take_lo ? lo_i : hi_i;
  end

endmodule

// File: rtl/picker_tree.sv
module picker_tree
  import picker_pkg::*;
#(
  parameter int N_LEAF = 16
) (
  input  cand_t leaf_i [N_LEAF],
  output cand_t root_o
);

  localparam int LVLS   = (N_LEAF > 1) ? $clog2(N_LEAF) : 1;
  localparam int P      = 1 << LVLS;
  localparam int N_NODE = 2 * P - 1;

  cand_t node [N_NODE];

  generate
    for (genvar g = 0; g < P; g++) begin : g_leaf
      if (g < N_LEAF) begin : g_real
        assign node[P-1+g] = leaf_i[g];
      end else begin : g_pad
        assign node[P-1+g] = '0;
      end
    end
    for (genvar k = 0; k < P - 1; k++) begin : g_node
      picker_merge_node u_merge (
        .lo_i  (node[2*k+1]),
        .hi_i  (node[2*k+2]),
        .win_o (node[k])
      );
    end
  endgenerate

  assign root_o = node[0];

endmodule

// File: rtl/rank_issue_picker.sv
module rank_issue_picker
  import picker_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_ENTRIES-1:0]         ready_i,
  input  logic [N_ENTRIES-1:0]         busy_i,
  input  logic [N_ENTRIES*SEQ_W-1:0]   seq_i,
  input  logic [N_ENTRIES*USE_W-1:0]   users_i,
  output logic [N_ENTRIES-1:0]         grant_o,
  output logic [IDX_W-1:0]             sel_idx_o,
  output logic                         found_o
);

  cand_t leaf  [N_ENTRIES];
  cand_t root;

  generate
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
      picker_rank_leaf #(.SLOT(i)) u_leaf (
        .ready_i (ready_i[i]),
        .busy_i  (busy_i[i]),
        .seq_i   (seq_i[i*SEQ_W +: SEQ_W]),
        .users_i (users_i[i*USE_W +: USE_W]),
        .cand_o  (leaf[i])
      );
    end
  endgenerate

  picker_tree #(.N_LEAF(N_ENTRIES)) u_tree (
    .leaf_i (leaf),
    .root_o (root)
  );

  // next-state
  logic                 found_d;
  logic [IDX_W-1:0]     idx_d;
  logic [N_ENTRIES-1:0] grant_d;

  always_comb begin
    found_d = root.vld;
    idx_d   = root.vld ? root.idx : '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      grant_d[i] = found_d && (idx_d == IDX_W'(i));
    end
  end

  // registers
  logic                 found_q;
  logic [IDX_W-1:0]     idx_q;
  logic [N_ENTRIES-1:0] grant_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      idx_q   <= '0;
      grant_q <= '0;
    end else begin
      found_q <= found_d;
      idx_q   <= idx_d;
      grant_q <= grant_d;
    end
  end

  assign found_o   = found_q;
  assign sel_idx_o = idx_q;
  assign grant_o   = grant_q;

endmodule

// File: rtl/picker_checker.sv
module picker_checker
  import picker_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [N_ENTRIES-1:0]       ready_i,
  input logic [N_ENTRIES-1:0]       busy_i,
  input logic [N_ENTRIES*SEQ_W-1:0] seq_i,
  input logic [N_ENTRIES*USE_W-1:0] users_i,
  input logic [N_ENTRIES-1:0]       grant_o,
  input logic [IDX_W-1:0]           sel_idx_o,
  input logic                       found_o
);

  logic                       snap_ok;
  logic [N_ENTRIES-1:0]       snap_elig;
  logic [N_ENTRIES*SEQ_W-1:0] snap_seq;
  logic [N_ENTRIES*USE_W-1:0] snap_use;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_ok   <= 1'b0;
      snap_elig <= '0;
      snap_seq  <= '0;
      snap_use  <= '0;
    end else begin
      snap_ok   <= 1'b1;
      snap_elig <= ready_i & ~busy_i;
      snap_seq  <= seq_i;
      snap_use  <= users_i;
    end
  end

  logic better_rank, better_seq, better_idx;

  always_comb begin
    int sel_r, sel_s, r_j, s_j;
    better_rank = 1'b0;
    better_seq  = 1'b0;
    better_idx  = 1'b0;
    sel_s = int'(snap_seq[sel_idx_o*SEQ_W +: SEQ_W]);
    sel_r = sel_s - int'(snap_use[sel_idx_o*USE_W +: USE_W]);
    for (int j = 0; j < N_ENTRIES; j++) begin
      s_j = int'(snap_seq[j*SEQ_W +: SEQ_W]);
      r_j = s_j - int'(snap_use[j*USE_W +: USE_W]);
      if (snap_elig[j]) begin
        if (r_j < sel_r) better_rank = 1'b1;
        if (r_j == sel_r && s_j < sel_s) better_seq = 1'b1;
        if (r_j == sel_r && s_j == sel_s && j < int'(sel_idx_o)) better_idx = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R9

  AST_GRANT_AT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> grant_o[sel_idx_o]); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> (grant_o == '0 && sel_idx_o == '0)); // R7

  AST_NONE_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && snap_elig == '0) |-> !found_o); // R7

  AST_ANY_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && snap_elig != '0) |-> found_o); // R8

  AST_PICK_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && found_o) |-> snap_elig[sel_idx_o]); // R5

  AST_RANK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && found_o) |-> !better_rank); // R2

  AST_SEQ_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && found_o) |-> !better_seq); // R3

  AST_IDX_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ok && found_o) |-> !better_idx); // R4

endmodule

bind rank_issue_picker picker_checker #(.N_ENTRIES(N_ENTRIES)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready_i   (ready_i),
  .busy_i    (busy_i),
  .seq_i     (seq_i),
  .users_i   (users_i),
  .grant_o   (grant_o),
  .sel_idx_o (sel_idx_o),
  .found_o   (found_o)
);

// File: tb/test_rank_issue_picker.sv
`timescale 1ns/1ps
module test_rank_issue_picker;

  localparam int N = 16;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] ready_i, busy_i;
  logic [N*8-1:0] seq_i;
  logic [N*4-1:0] users_i;
  logic [N-1:0] grant_o;
  logic [3:0]   sel_idx_o;
  logic         found_o;

  logic [7:0] b_seq [N];
  logic [3:0] b_use [N];
  logic       b_rdy [N];
  logic       b_bsy [N];

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R10";
  bit    chk_on  = 0;
  bit    done    = 0;

  logic       exp_found;
  logic [3:0] exp_idx;

  rank_issue_picker #(.N_ENTRIES(N)) i_rank_issue_picker (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .busy_i(busy_i),
    .seq_i(seq_i), .users_i(users_i), .grant_o(grant_o),
    .sel_idx_o(sel_idx_o), .found_o(found_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      seq_i[i*8 +: 8]   = b_seq[i];
      users_i[i*4 +: 4] = b_use[i];
      ready_i[i]        = b_rdy[i];
      busy_i[i]         = b_bsy[i];
    end
  end

  // behavioural reference: scan every slot, keep best by (score, tag, index)
  task automatic model(output logic f, output logic [3:0] ix);
    int best_r, best_s, r, s;
    f = 0; ix = 0; best_r = 0; best_s = 0;
    for (int i = 0; i < N; i++) begin
      if (b_rdy[i] && !b_bsy[i]) begin
        s = int'(b_seq[i]);
        r = s - int'(b_use[i]);
        if (!f || r < best_r || (r == best_r && s < best_s)) begin
          f = 1; ix = 4'(i); best_r = r; best_s = s;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    logic f; logic [3:0] ix;
    if (!rst_n) begin
      exp_found <= 0; exp_idx <= 0;
    end else begin
      model(f, ix);
      exp_found <= f; exp_idx <= ix;
    end
  end

  function automatic logic [N-1:0] onehot(input logic f, input logic [3:0] ix);
    logic [N-1:0] v = '0;
    if (f) v[ix] = 1'b1;
    return v;
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (chk_on && !done) begin
      n_tests++;
      if (found_o !== exp_found || sel_idx_o !== exp_idx ||
          grant_o !== onehot(exp_found, exp_idx)) begin
        n_fail++;
        $display("FAIL %s cycle: found/idx/grant act=%0b/%0d/%h exp=%0b/%0d/%h",
                 cur_req, found_o, sel_idx_o, grant_o,
                 exp_found, exp_idx, onehot(exp_found, exp_idx));
      end
    end
  end

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      b_seq[i] = 8'(i); b_use[i] = 0; b_rdy[i] = 0; b_bsy[i] = 0;
    end
  endtask

  task automatic set_slot(int i, int s, int u, bit rdy, bit bsy);
    b_seq[i] = 8'(s); b_use[i] = 4'(u); b_rdy[i] = rdy; b_bsy[i] = bsy;
  endtask

  // directed check against a hand-computed answer, one edge after driving
  task automatic expect_pick(string req, logic f, logic [3:0] ix);
    @(negedge clk);
    n_tests++;
    if (found_o !== f || sel_idx_o !== ix || grant_o !== onehot(f, ix)) begin
      n_fail++;
      $display("FAIL %s direct: found/idx/grant act=%0b/%0d/%h exp=%0b/%0d/%h",
               req, found_o, sel_idx_o, grant_o, f, ix, onehot(f, ix));
    end
  endtask

  task automatic summary();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  initial begin
    clear_all();
    for (int i = 0; i < N; i++) b_rdy[i] = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: outputs stay zero in reset even with eligible slots present
    n_tests++;
    if (found_o !== 0 || grant_o !== '0 || sel_idx_o !== 0) begin
      n_fail++;
      $display("FAIL R10: act=%0b/%0d/%h exp=0/0/0", found_o, sel_idx_o, grant_o);
    end
    clear_all();
    rst_n = 1;
    chk_on = 1;

    // R1: negative score (2-9=-7) beats older tag with score 1
    cur_req = "R1";
    clear_all();
    set_slot(0, 1, 0, 1, 0);
    set_slot(3, 2, 9, 1, 0);
    expect_pick("R1", 1, 3);

    // R2: score 7 (12-5) beats score 10
    cur_req = "R2";
    clear_all();
    set_slot(1, 10, 0, 1, 0);
    set_slot(5, 12, 5, 1, 0);
    expect_pick("R2", 1, 5);

    // R5: best slot busy -> next best
    cur_req = "R5";
    b_bsy[5] = 1;
    expect_pick("R5", 1, 1);

    // R6: best slot not ready -> next best
    cur_req = "R6";
    b_bsy[5] = 0; b_rdy[5] = 0;
    expect_pick("R6", 1, 1);

    // R3: equal score 16, older tag 18 wins over 20 even at higher index
    cur_req = "R3";
    clear_all();
    set_slot(2, 20, 4, 1, 0);
    set_slot(7, 18, 2, 1, 0);
    expect_pick("R3", 1, 7);

    // R4: identical score and tag -> lowest index
    cur_req = "R4";
    clear_all();
    set_slot(9, 30, 3, 1, 0);
    set_slot(4, 30, 3, 1, 0);
    expect_pick("R4", 1, 4);

    // R7: everything ready but busy, then nothing ready
    cur_req = "R7";
    clear_all();
    for (int i = 0; i < N; i++) begin b_rdy[i] = 1; b_bsy[i] = 1; end
    expect_pick("R7", 0, 0);
    clear_all();
    expect_pick("R7", 0, 0);

    // R8: pattern changes every cycle, each pick appears one edge later
    cur_req = "R8";
    for (int c = 0; c < 8; c++) begin
      clear_all();
      set_slot(c, 40, 0, 1, 0);
      set_slot(15 - c, 50, 15, 1, 0);
      expect_pick("R8", 1, (c < 8 && 35 < 40) ? 4'(15 - c) : 4'(c));
    end

    // R9: random traffic, tags confined to a 100-value window
    cur_req = "R9";
    for (int c = 0; c < 400; c++) begin
      int base;
      @(negedge clk);
      base = $urandom_range(0, 127);
      for (int i = 0; i < N; i++) begin
        b_seq[i] = 8'(base + $urandom_range(0, 99));
        b_use[i] = 4'($urandom_range(0, 15));
        b_rdy[i] = ($urandom_range(0, 3) != 0);
        b_bsy[i] = ($urandom_range(0, 3) == 0);
      end
    end
    // R4 stress: all slots identical
    cur_req = "R4";
    @(negedge clk);
    for (int i = 0; i < N; i++) set_slot(i, 60, 6, 1, (i < 6));
    expect_pick("R4", 1, 6);

    @(negedge clk);
    summary();
  end

endmodule